// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a register-mapped watchdog for a system controller. Software programs a timeout value, clears a halt bit to start the countdown, and must keep writing a reload register to keep the counter from running out. The counter steps down once per pulse on a tick-enable input. When it runs out the first time, the block raises a timeout flag, can drive a management interrupt, and restarts the count by itself. If it runs out again before software reloads it, the block records a second-timeout flag and asks the reset generator for a system reset, unless a no-reboot control is set.

Status flags are write-one-to-clear. The second-timeout and boot flags sit in a power-on domain, so they survive the system reset the watchdog itself requests and software can read after restart that a watchdog reset happened. A lock bit freezes the no-reboot control until the next reset. Registers are reached through a simple halfword bus with byte enables; reads are combinational on the address.

Register map (address: contents): 0 reload strobe on write, current count on read; 1 timer value, low TMR_W bits are the timeout field; 2 first-timeout flag in bit 0; 3 second-timeout flag in bit 0, boot flag in bit 1; 4 control, halt in bit 11, a stored spare bit in bit 9; 5 interrupt enable in bit 0; 6 no-reboot in bit 0, lock in bit 1; 7 reads zero.

Top module: `wdt_two_stage`

## Requirements
- R1: After power-on reset the control reads 0x0800 (halted), the timer value and the count read TMR_RST (20), no-reboot reads 1 with lock 0, interrupt enable and the first-timeout flag read 0, register 3 reads 0x0002 (boot set, second-timeout clear) and sys_rst_o is 0.
- R2: Status flags at addresses 2 and 3 clear only when a 1 is written to their bit with byte lane 0 enabled; writing 0 leaves them set, and a hardware set in the same cycle wins over a clear.
- R3: While control bit 11 (halt) is 0, each cycle with tick_i high lowers the count by one; while it is 1 the count holds.
- R4: Control writes with byte lane 1 enabled store bit 11 and bit 9; every other control bit reads 0 whatever was written.
- R5: A write to address 0 with byte lane 0 enabled and any of data bits 4..0 set loads the count from the timeout field and forgets an earlier first expiry; any other write to address 0 changes nothing.
- R6: A timer-value write merges by byte lanes, raises a field below TMR_MIN (4) to TMR_MIN, keeps the bits above the field as written, and does not change the count until the next reload or expiry.
- R7: A tick that finds the count at 1 with no earlier unanswered expiry sets the first-timeout flag (address 2 bit 0) and reloads the count from the timeout field.
- R8: A tick that finds the count at 1 after an unanswered first expiry sets the second-timeout flag (address 3 bit 0), reloads the count, and drives sys_rst_o high for RST_CYC (4) cycles starting right after that clock edge.
- R9: With no-reboot (address 6 bit 0) at 1 a second expiry still sets its flag but sys_rst_o stays 0.
- R10: Writing 1 to address 6 bit 1 sets the lock; while locked, writes leave both no-reboot and lock unchanged until rst_ni.
- R11: smi_o is high exactly while the first-timeout flag and the interrupt enable (address 5 bit 0) are both 1.
- R12: rst_ni returns everything to the R1 state except the second-timeout and boot flags, which only por_ni clears and sets respectively.
- R13: A write to address 3 with both bit 0 and bit 1 set clears only the second-timeout flag; the boot flag needs its own write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| por_ni | input | 1 | Power-on reset, active low, clears every register including sticky flags |
| rst_ni | input | 1 | System reset, active low, spares the second-timeout and boot flags |
| tick_i | input | 1 | Count enable, one decrement per high cycle |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Register address |
| bus_be_i | input | 2 | Byte lane enables for writes |
| bus_wdata_i | input | 16 | Write data |
| bus_rdata_o | output | 16 | Read data for bus_addr_i |
| smi_o | output | 1 | Management interrupt request |
| sys_rst_o | output | 1 | System reset request pulse |

## Verification
The countdown is driven with ticks under halt and with halt cleared, so a counter that ignores the halt bit or steps on idle cycles shows at once. Expiry is tried three ways: two expiries in a row with no-reboot set, two in a row with it clear, and an expiry, a software reload and another expiry, which separates a correct first-expiry memory from one that a reload fails to clear. Writes to the reload, timer, status and lock registers are sent with lanes and data bits that must have no effect next to ones that must, and every register is read back each cycle against the reference model.

// File: rtl/wdt_pkg.sv
`timescale 1ns/1ps
package wdt_pkg;
  localparam logic [2:0] A_RLD  = 3'd0;
  localparam logic [2:0] A_TMR  = 3'd1;
  localparam logic [2:0] A_STS1 = 3'd2;
  localparam logic [2:0] A_STS2 = 3'd3;
  localparam logic [2:0] A_CTRL = 3'd4;
  localparam logic [2:0] A_EN   = 3'd5;
  localparam logic [2:0] A_GCS  = 3'd6;

  localparam int CTRL_HALT_BIT = 11;
  localparam int CTRL_KEEP_BIT = 9;
  localparam int RLD_MASK_W    = 5;

  typedef struct packed {
    logic tmo_set;
    logic second_set;
  } wdt_evt_t;

  function automatic logic [15:0] be_merge(input logic [15:0] old_v,
                                           input logic [15:0] new_v,
                                           input logic [1:0]  be);
    return {be[1] ? new_v[15:8] : old_v[15:8], be[0] ? new_v[7:0] : old_v[7:0]};
  endfunction
endpackage

// File: rtl/wdt_counter.sv
`timescale 1ns/1ps
module wdt_counter #(
  parameter int TMR_W   = 10,
  parameter int TMR_RST = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             halt_i,
  input  logic             reload_i,
  input  logic [TMR_W-1:0] load_val_i,
  input  logic             no_reboot_i,
  output logic [TMR_W-1:0] cnt_o,
  output wdt_pkg::wdt_evt_t evt_o,
  output logic             fire_o
);
  logic [TMR_W-1:0] cnt_q;
  logic             first_q;
  logic             step;
  logic             expire;

  assign step   = tick_i && !halt_i && !reload_i;
  assign expire = step && (cnt_q <= TMR_W'(1));

  assign evt_o.tmo_set    = expire && !first_q;
  assign evt_o.second_set = expire && first_q;
  assign fire_o           = expire && first_q && !no_reboot_i;
  assign cnt_o            = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= TMR_W'(TMR_RST);
      first_q <= 1'b0;
    end else if (reload_i) begin
      cnt_q   <= load_val_i;
      first_q <= 1'b0;
    end else if (step) begin
      if (expire) begin
        cnt_q   <= load_val_i;
        first_q <= !first_q;
      end else begin
        cnt_q <= cnt_q - TMR_W'(1);
      end
    end
  end

  a_r3_halt_freezes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_i && !reload_i |=> $stable(cnt_q));
  a_r3_tick_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i && !halt_i && !reload_i && cnt_q > TMR_W'(1) |=> cnt_q == $past(cnt_q) - TMR_W'(1));
  a_r5_reload_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> cnt_q == $past(load_val_i));
endmodule

// File: rtl/wdt_rst_pulse.sv
`timescale 1ns/1ps
module wdt_rst_pulse #(
  parameter int RST_CYC = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  output logic rst_o
);
  localparam int PW = $clog2(RST_CYC + 1);
  logic [PW-1:0] left_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             left_q <= '0;
    else if (fire_i)         left_q <= PW'(RST_CYC);
    else if (left_q != '0)   left_q <= left_q - PW'(1);
  end

  assign rst_o = (left_q != '0);

  a_r8_pulse_starts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> rst_o);
endmodule

// File: rtl/wdt_regs.sv
`timescale 1ns/1ps
module wdt_regs
  import wdt_pkg::*;
#(
  parameter int TMR_W   = 10,
  parameter int TMR_MIN = 4,
  parameter int TMR_RST = 20
) (
  input  logic             clk_i,
  input  logic             por_ni,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [1:0]       be_i,
  input  logic [15:0]      wdata_i,
  input  logic [TMR_W-1:0] cnt_i,
  input  wdt_evt_t         evt_i,
  output logic [15:0]      rdata_o,
  output logic             reload_o,
  output logic [TMR_W-1:0] load_val_o,
  output logic             halt_o,
  output logic             no_reboot_o,
  output logic             smi_o
);
  localparam logic [15:0] FIELD_MASK = 16'((32'd1 << TMR_W) - 32'd1);
  localparam logic [15:0] MIN_V      = 16'(TMR_MIN);

  logic [15:0] tmr_q, tmr_next;
  logic tmo_q, second_q, boot_q, halt_q, keep_q, smi_en_q, no_reboot_q, lock_q;
  logic wr_tmr, wr_sts1, wr_sts2, wr_ctrl, wr_en, wr_gcs;
  logic clr_tmo, clr_second, clr_boot;

  assign wr_tmr  = we_i && addr_i == A_TMR;
  assign wr_sts1 = we_i && addr_i == A_STS1 && be_i[0];
  assign wr_sts2 = we_i && addr_i == A_STS2 && be_i[0];
  assign wr_ctrl = we_i && addr_i == A_CTRL && be_i[1];
  assign wr_en   = we_i && addr_i == A_EN   && be_i[0];
  assign wr_gcs  = we_i && addr_i == A_GCS  && be_i[0];

  assign reload_o   = we_i && addr_i == A_RLD && be_i[0] && (|wdata_i[RLD_MASK_W-1:0]);
  assign clr_tmo    = wr_sts1 && wdata_i[0];
  assign clr_second = wr_sts2 && wdata_i[0];
  // both bits in one write: only the second-timeout flag goes
  assign clr_boot   = wr_sts2 && !wdata_i[0] && wdata_i[1];

  always_comb begin
    tmr_next = be_merge(tmr_q, wdata_i, be_i);
    if ((tmr_next & FIELD_MASK) < MIN_V)
      tmr_next = (tmr_next & ~FIELD_MASK) | MIN_V;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tmr_q       <= 16'(TMR_RST);
      tmo_q       <= 1'b0;
      halt_q      <= 1'b1;
      keep_q      <= 1'b0;
      smi_en_q    <= 1'b0;
      no_reboot_q <= 1'b1;
      lock_q      <= 1'b0;
    end else begin
      if (wr_tmr) tmr_q <= tmr_next;
      if (evt_i.tmo_set) tmo_q <= 1'b1;
      else if (clr_tmo)  tmo_q <= 1'b0;
      if (wr_ctrl) begin
        halt_q <= wdata_i[CTRL_HALT_BIT];
        keep_q <= wdata_i[CTRL_KEEP_BIT];
      end
      if (wr_en) smi_en_q <= wdata_i[0];
      if (wr_gcs && !lock_q) begin
        no_reboot_q <= wdata_i[0];
        lock_q      <= wdata_i[1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge por_ni) begin
    if (!por_ni) begin
      second_q <= 1'b0;
      boot_q   <= 1'b1;
    end else begin
      if (evt_i.second_set) second_q <= 1'b1;
      else if (clr_second)  second_q <= 1'b0;
      if (clr_boot) boot_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_RLD:  rdata_o = 16'(cnt_i);
      A_TMR:  rdata_o = tmr_q;
      A_STS1: rdata_o[0] = tmo_q;
      A_STS2: rdata_o[1:0] = {boot_q, second_q};
      A_CTRL: begin
        rdata_o[CTRL_HALT_BIT] = halt_q;
        rdata_o[CTRL_KEEP_BIT] = keep_q;
      end
      A_EN:   rdata_o[0] = smi_en_q;
      A_GCS:  rdata_o[1:0] = {lock_q, no_reboot_q};
      default: rdata_o = '0;
    endcase
  end

  assign load_val_o  = tmr_q[TMR_W-1:0];
  assign halt_o      = halt_q;
  assign no_reboot_o = no_reboot_q;
  assign smi_o       = tmo_q && smi_en_q;

  a_r2_w1c_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_tmo && !evt_i.tmo_set |=> !tmo_q);
  a_r2_set_sticks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    evt_i.tmo_set |=> tmo_q);
  a_r10_lock_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lock_q |=> lock_q && $stable(no_reboot_q));
endmodule

// File: rtl/wdt_two_stage.sv
`timescale 1ns/1ps
module wdt_two_stage
  import wdt_pkg::*;
#(
  parameter int TMR_W   = 10,
  parameter int TMR_MIN = 4,
  parameter int TMR_RST = 20,
  parameter int RST_CYC = 4
) (
  input  logic        clk_i,
  input  logic        por_ni,
  input  logic        rst_ni,
  input  logic        tick_i,
  input  logic        bus_we_i,
  input  logic [2:0]  bus_addr_i,
  input  logic [1:0]  bus_be_i,
  input  logic [15:0] bus_wdata_i,
  output logic [15:0] bus_rdata_o,
  output logic        smi_o,
  output logic        sys_rst_o
);
  logic             rst_n;
  logic [TMR_W-1:0] cnt, load_val;
  logic             reload, halt, no_reboot, fire;
  wdt_evt_t         evt;

  assign rst_n = rst_ni && por_ni;

  wdt_regs #(.TMR_W(TMR_W), .TMR_MIN(TMR_MIN), .TMR_RST(TMR_RST)) u_regs (
    .clk_i, .por_ni, .rst_ni(rst_n),
    .we_i(bus_we_i), .addr_i(bus_addr_i), .be_i(bus_be_i), .wdata_i(bus_wdata_i),
    .cnt_i(cnt), .evt_i(evt), .rdata_o(bus_rdata_o),
    .reload_o(reload), .load_val_o(load_val), .halt_o(halt),
    .no_reboot_o(no_reboot), .smi_o
  );

  wdt_counter #(.TMR_W(TMR_W), .TMR_RST(TMR_RST)) u_counter (
    .clk_i, .rst_ni(rst_n), .tick_i, .halt_i(halt), .reload_i(reload),
    .load_val_i(load_val), .no_reboot_i(no_reboot),
    .cnt_o(cnt), .evt_o(evt), .fire_o(fire)
  );

  wdt_rst_pulse #(.RST_CYC(RST_CYC)) u_pulse (
    .clk_i, .rst_ni(rst_n), .fire_i(fire), .rst_o(sys_rst_o)
  );

  a_r9_noreboot_masks: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(sys_rst_o) |-> !$past(no_reboot));
  a_r8_second_needs_ticks: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(sys_rst_o) |-> $past(tick_i));
endmodule

// File: tb/wdt_two_stage_bench.sv
`timescale 1ns/1ps
module wdt_two_stage_bench;
  localparam int TMR_W = 10, TMR_MIN = 4, TMR_RST = 20, RST_CYC = 4;
  localparam int FMASK = (1 << TMR_W) - 1;

  logic clk = 0, por_n = 0, rst_n = 0, tick = 0, we = 0;
  logic [2:0] addr = 0;
  logic [1:0] be = 0;
  logic [15:0] wdata = 0, rdata;
  logic smi, sys_rst;

  wdt_two_stage #(.TMR_W(TMR_W), .TMR_MIN(TMR_MIN), .TMR_RST(TMR_RST), .RST_CYC(RST_CYC))
  u_wdt_two_stage (
    .clk_i(clk), .por_ni(por_n), .rst_ni(rst_n), .tick_i(tick), .bus_we_i(we),
    .bus_addr_i(addr), .bus_be_i(be), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .smi_o(smi), .sys_rst_o(sys_rst)
  );

  always #5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  string phase = "R1";

  // reference model state
  int m_cnt, m_first, m_tmr, m_tmo, m_second, m_boot, m_halt, m_keep;
  int m_en, m_nr, m_lock, m_rcnt;

  task automatic model_rst(input bit por);
    m_cnt = TMR_RST; m_first = 0; m_tmr = TMR_RST; m_tmo = 0; m_halt = 1;
    m_keep = 0; m_en = 0; m_nr = 1; m_lock = 0; m_rcnt = 0;
    if (por) begin m_second = 0; m_boot = 1; end
  endtask

  always @(posedge clk) begin
    if (!por_n) model_rst(1);
    else if (!rst_n) model_rst(0);
    else begin
      int ncnt, nfirst, tset, sset, fire, wd, m;
      wd = int'(wdata);
      ncnt = m_cnt; nfirst = m_first; tset = 0; sset = 0; fire = 0;
      if (we && addr == 0 && be[0] && (wd & 31) != 0) begin
        ncnt = m_tmr & FMASK; nfirst = 0;
      end else if (tick && !m_halt) begin
        if (m_cnt <= 1) begin
          ncnt = m_tmr & FMASK;
          if (m_first == 0) begin tset = 1; nfirst = 1; end
          else begin sset = 1; nfirst = 0; fire = !m_nr; end
        end else ncnt = m_cnt - 1;
      end
      if (fire) m_rcnt = RST_CYC; else if (m_rcnt > 0) m_rcnt--;
      if (we) begin
        case (addr)
          3'd1: begin
            m = ((be[1] ? wd : m_tmr) & 16'hFF00) | ((be[0] ? wd : m_tmr) & 16'h00FF);
            if ((m & FMASK) < TMR_MIN) m = (m & ~FMASK & 16'hFFFF) | TMR_MIN;
            m_tmr = m;
          end
          3'd2: if (be[0] && wd[0]) m_tmo = 0;
          3'd3: if (be[0]) begin
            if (wd[0]) m_second = 0; else if (wd[1]) m_boot = 0;
          end
          3'd4: if (be[1]) begin m_halt = wd[11]; m_keep = wd[9]; end
          3'd5: if (be[0]) m_en = wd[0];
          3'd6: if (be[0] && !m_lock) begin m_nr = wd[0]; m_lock = wd[1]; end
          default: ;
        endcase
      end
      if (tset) m_tmo = 1;
      if (sset) m_second = 1;
      m_cnt = ncnt; m_first = nfirst;
    end
  end

  function automatic int m_read(input int a);
    case (a)
      0: return m_cnt;
      1: return m_tmr;
      2: return m_tmo;
      3: return m_second | (m_boot << 1);
      4: return (m_halt << 11) | (m_keep << 9);
      5: return m_en;
      6: return m_nr | (m_lock << 1);
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input int got, input int exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  // one clock, then compare every register and both outputs with the model
  task automatic cycle();
    logic [2:0] saved;
    int bad;
    @(posedge clk); @(negedge clk);
    saved = addr; bad = 0;
    for (int a = 0; a < 8; a++) begin
      addr = 3'(a); #0.2;
      if (int'(rdata) != m_read(a)) begin
        bad = 1;
        $display("FAIL %s: reg %0d got %0h expected %0h", phase, a, rdata, m_read(a));
      end
    end
    addr = saved; #0.1;
    if (smi !== ((m_tmo && m_en) ? 1'b1 : 1'b0)) begin
      bad = 1; $display("FAIL %s: smi_o got %0b expected %0b", phase, smi, m_tmo && m_en);
    end
    if (sys_rst !== ((m_rcnt != 0) ? 1'b1 : 1'b0)) begin
      bad = 1; $display("FAIL %s: sys_rst_o got %0b expected %0b", phase, sys_rst, m_rcnt != 0);
    end
    n_chk++;
    if (bad) n_fail++;
  endtask

  task automatic wr(input int a, input int d, input int b);
    we = 1; addr = 3'(a); wdata = 16'(d); be = 2'(b);
    cycle();
    we = 0; be = 0;
  endtask

  task automatic rd(input int a, output int v);
    addr = 3'(a); #0.2; v = int'(rdata);
  endtask

  task automatic ticks(input int n);
    tick = 1;
    repeat (n) cycle();
    tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: run did not finish");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    int v, hi;
    repeat (3) cycle();
    por_n = 1; rst_n = 1;
    cycle();
    // R1 reset state
    rd(4, v); chk("R1 ctrl", v, 16'h0800);
    rd(1, v); chk("R1 tmr", v, TMR_RST);
    rd(0, v); chk("R1 cnt", v, TMR_RST);
    rd(6, v); chk("R1 gcs", v, 1);
    rd(3, v); chk("R1 sts2", v, 2);
    chk("R1 sys_rst_o", int'(sys_rst), 0);

    phase = "R13";
    wr(3, 3, 3);  rd(3, v); chk("R13 boot kept", v, 2);
    wr(3, 2, 3);  rd(3, v); chk("R13 boot cleared", v, 0);

    phase = "R4";
    wr(4, 16'hFFFF, 3); rd(4, v); chk("R4 ctrl mask", v, 16'h0A00);
    wr(4, 16'h0200, 1); rd(4, v); chk("R4 lane0 ignored", v, 16'h0A00);
    wr(4, 16'h0200, 2); rd(4, v); chk("R4 ctrl run", v, 16'h0200);

    phase = "R6";
    wr(1, 2, 3);        rd(1, v); chk("R6 clamp min", v, 4);
    wr(1, 16'hFC08, 3); rd(1, v); chk("R6 upper kept", v, 16'hFC08);
    wr(1, 16'h0010, 1); rd(1, v); chk("R6 lane merge", v, 16'hFC10);
    rd(0, v); chk("R6 count untouched", v, TMR_RST);

    phase = "R3";
    ticks(3);           rd(0, v); chk("R3 counts", v, 17);
    wr(4, 16'h0800, 3);
    ticks(3);           rd(0, v); chk("R3 halt holds", v, 17);

    phase = "R5";
    wr(0, 16'h0020, 3); rd(0, v); chk("R5 no low bits", v, 17);
    wr(0, 16'h0001, 2); rd(0, v); chk("R5 lane1 only", v, 17);
    wr(0, 16'h0001, 1); rd(0, v); chk("R5 reload", v, 16);

    phase = "R7";
    wr(5, 1, 1);
    wr(1, 5, 3);
    wr(0, 1, 1);
    wr(4, 0, 2);
    ticks(5);
    rd(2, v); chk("R7 first flag", v, 1);
    rd(0, v); chk("R7 auto reload", v, 5);
    chk("R11 smi on", int'(smi), 1);
    phase = "R2";
    wr(2, 0, 3); rd(2, v); chk("R2 zero no effect", v, 1);
    wr(2, 1, 3); rd(2, v); chk("R2 w1c", v, 0);
    chk("R11 smi off", int'(smi), 0);

    phase = "R9";
    ticks(5);
    rd(3, v); chk("R9 second flag", v, 1);
    hi = 0;
    repeat (6) begin cycle(); if (sys_rst) hi++; end
    chk("R9 no pulse", hi, 0);

    phase = "R8";
    wr(3, 1, 1);
    wr(6, 0, 1);  rd(6, v); chk("R10 unlocked write", v, 0);
    wr(0, 1, 1);
    ticks(5);     rd(2, v); chk("R7 flag again", v, 1);
    ticks(4);
    wr(0, 1, 1);
    phase = "R5";
    ticks(5);     rd(3, v); chk("R5 reload forgets first", v, 0);
    chk("R5 no pulse", int'(sys_rst), 0);
    phase = "R8";
    ticks(4);
    ticks(1);
    chk("R8 pulse starts", int'(sys_rst), 1);
    rd(3, v); chk("R8 second flag", v, 1);
    hi = 1;
    repeat (6) begin cycle(); if (sys_rst) hi++; end
    chk("R8 pulse length", hi, RST_CYC);

    phase = "R12";
    rst_n = 0; repeat (2) cycle(); rst_n = 1; cycle();
    rd(3, v); chk("R12 second survives", v, 1);
    rd(4, v); chk("R12 ctrl reset", v, 16'h0800);
    rd(1, v); chk("R12 tmr reset", v, TMR_RST);
    por_n = 0; repeat (2) cycle(); por_n = 1; cycle();
    rd(3, v); chk("R12 por clears", v, 2);

    phase = "R10";
    wr(6, 3, 1); rd(6, v); chk("R10 locked", v, 3);
    wr(6, 0, 1); rd(6, v); chk("R10 write ignored", v, 3);
    rst_n = 0; cycle(); rst_n = 1; cycle();
    rd(6, v); chk("R10 rst unlocks", v, 1);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule